// File: doc/BRIEF.md
# Configurable UART Frame Engine

This block is the serial core of an asynchronous serial port. It turns bytes into framed bit streams on a transmit line, and turns frames seen on a receive line back into bytes, each with a status byte. A 21-bit divider gives the number of input clock cycles per serial bit. A 6-bit line-control word selects the data length (5 to 8 bits), one or two stop bits, and parity (none, even or odd). The frame format is a low start bit, then the data bits least significant first, then an optional parity bit, then high stop bits.

Both FIFOs live outside the block. On the transmit side the block pops a show-ahead FIFO: the byte at its head is taken in the cycle that pop is high. On the receive side it pushes one data byte together with a status byte. The status byte reports break, overrun, framing error and parity error. A break marks that character's framing and parity flags as not applicable. A loopback control feeds the transmit line into the receiver in place of the external input, which lets the whole path be tested inside the chip.

Top module: `uart_frame_engine`

## Requirements
- R1: While reset is high and after it is released, `serial_out` is 1, `rx_fifo_push` and `tx_fifo_pop` are 0, and `tx_done` is 1 whenever the transmit FIFO is empty.
- R2: A transmitted frame starts with one low bit. The data bits follow, least significant first. The data length comes from `line_ctrl[3:2]`: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Each bit lasts one divider period.
- R3: `line_ctrl[1]` = 1 inserts a parity bit after the data. `line_ctrl[0]` = 0 selects even parity and 1 selects odd parity. Even parity makes the count of ones in the data and parity bit together even; odd parity makes it odd.
- R4: `line_ctrl[5:4]` = 11 sends two high stop bits. The value 01 sends one. The receiver checks every configured stop bit.
- R5: The bit period is `{baud_div_hi, baud_div_lo}` clock cycles, a 21-bit value. Values below 2 act as 2.
- R6: The transmitter pops exactly one byte per frame. It pops only when the FIFO is not empty, and it starts the next frame without a gap beyond one idle cycle.
- R7: `tx_done` is 1 exactly when no frame is being shifted out and the transmit FIFO is empty. It rises one frame length, measured in bit periods times the divider, after the start bit begins.
- R8: The receiver samples each bit at its midpoint. A low pulse on the line that has ended before the start bit's midpoint produces no character.
- R9: Each received character gives a single-cycle push of the data byte, with unused high bits set to 0, and a status byte. In the status byte, bit 7 is break, bit 4 is overrun, bit 3 is framing error, bit 2 is parity error, and all other bits are 0.
- R10: A parity bit that does not match the configured parity sets status bit 2. A low level sampled in any stop bit sets status bit 3.
- R11: A frame that stays low through the data, the parity bit and all stop bits is a break. It is pushed with data 0 and status 0x80: the framing and parity flags read 0. The receiver then waits for the line to go high before it looks for a new start bit.
- R12: A character that completes while `rx_fifo_full` is 1 is dropped. The next character that is stored carries status bit 4. The character after that does not.
- R13: With `loop_en` = 1 the receiver takes the transmit line, and `serial_in` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_div_lo | input | 16 | Divider bits 15:0 |
| baud_div_hi | input | 5 | Divider bits 20:16 |
| line_ctrl | input | 6 | Stop count [5:4], data length [3:2], parity enable [1], odd parity [0] |
| loop_en | input | 1 | Feed the transmit line to the receiver |
| tx_fifo_empty | input | 1 | Transmit FIFO has no byte |
| tx_fifo_data | input | 8 | Byte at the transmit FIFO head |
| tx_fifo_pop | output | 1 | Take the head byte this cycle |
| rx_fifo_full | input | 1 | Receive FIFO cannot accept a byte |
| rx_fifo_push | output | 1 | Store the received byte and status this cycle |
| rx_fifo_data | output | 8 | Received data byte |
| rx_fifo_status | output | 8 | Received character status |
| tx_done | output | 1 | Transmitter idle and FIFO empty |
| serial_in | input | 1 | Receive line |
| serial_out | output | 1 | Transmit line |

## Verification
A wrong bit counter or a latched configuration that is out of step shows up within one frame. On the transmit side it appears as a misplaced bit edge or a wrong frame length, which the bench measures through `tx_done`. On the receive side it appears as a byte with shifted or truncated data bits. A wrong sample phase or start-bit qualification shows up as spurious characters after short line glitches. Error-flag state that is left stale shows up in the next character's status byte. This is most visible for the overrun flag, which must appear on exactly one stored character, and for the receiver's wait for the line to go high after a break.

// File: rtl/uart_fe_pkg.sv
package uart_fe_pkg;
    localparam int DIV_LO_W = 16;
    localparam int DIV_HI_W = 5;
    localparam int DIV_W    = DIV_LO_W + DIV_HI_W;
    localparam int DATA_W   = 8;
    localparam int STAT_W   = 8;
    localparam int LCR_W    = 6;
    localparam int IDX_W    = $clog2(DATA_W);

    // status byte bit positions
    localparam int ST_BRK = 7;
    localparam int ST_OVR = 4;
    localparam int ST_FRM = 3;
    localparam int ST_PAR = 2;

    typedef struct packed {
        logic       two_stop;
        logic [1:0] len;
        logic       par_en;
        logic       par_odd;
    } frame_cfg_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_DATA,
        PH_PAR,
        PH_STOP,
        PH_HOLD
    } phase_t;

    function automatic frame_cfg_t decode_lcr(input logic [LCR_W-1:0] lcr);
        frame_cfg_t c;
        c.two_stop = (lcr[5:4] == 2'b11);
        c.len      = lcr[3:2];
        c.par_en   = lcr[1];
        c.par_odd  = lcr[0];
        return c;
    endfunction

    // index of the final data bit: 4..7 for 5..8 bits
    function automatic logic [IDX_W-1:0] last_idx(input logic [1:0] len);
        return IDX_W'(4) + IDX_W'(len);
    endfunction

    function automatic logic [DATA_W-1:0] len_mask(input logic [1:0] len);
        logic [DATA_W-1:0] m;
        m = '0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i <= int'(last_idx(len))) m[i] = 1'b1;
        end
        return m;
    endfunction

    function automatic logic parity_bit(input logic [DATA_W-1:0] d, input frame_cfg_t c);
        return (^(d & len_mask(c.len))) ^ c.par_odd;
    endfunction

    function automatic logic [DIV_W-1:0] eff_div(input logic [DIV_W-1:0] d);
        return (d < DIV_W'(2)) ? DIV_W'(2) : d;
    endfunction
endpackage

// File: rtl/uart_fe_sync.sv
module uart_fe_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sr;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sr <= {STAGES{RST_VAL}};
                else     sr <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sr <= {STAGES{RST_VAL}};
                else     sr <= {sr[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = sr[STAGES-1];
endmodule

// File: rtl/uart_fe_tx.sv
module uart_fe_tx
    import uart_fe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [DIV_W-1:0]  div,
    input  frame_cfg_t        cfg_in,
    input  logic              fifo_empty,
    input  logic [DATA_W-1:0] fifo_data,
    output logic              fifo_pop,
    output logic              txd,
    output logic              busy
);
    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    phase_t            ph;
    frame_cfg_t        cfg_q;
    logic [DIV_W-1:0]  cnt;
    logic [DIV_W-1:0]  div_q;
    logic [DATA_W-1:0] shreg;
    logic [IDX_W-1:0]  idx;
    logic              stop_left;
    logic              bit_end;

    assign bit_end  = (cnt == '0);
    assign fifo_pop = (ph == PH_IDLE) && !fifo_empty;
    assign busy     = (ph != PH_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph        <= PH_IDLE;
            txd       <= 1'b1;
            cnt       <= '0;
            div_q     <= DIV_W'(2);
            shreg     <= '0;
            idx       <= '0;
            cfg_q     <= '0;
            stop_left <= 1'b0;
        end else begin
            case (ph)
                PH_IDLE: begin
                    if (!fifo_empty) begin
                        div_q <= eff_div(div);
                        cnt   <= eff_div(div) - ONE;
                        cfg_q <= cfg_in;
                        shreg <= fifo_data;
                        idx   <= '0;
                        txd   <= 1'b0;
                        ph    <= PH_START;
                    end
                end
                PH_START: begin
                    if (bit_end) begin
                        cnt <= div_q - ONE;
                        txd <= shreg[0];
                        idx <= '0;
                        ph  <= PH_DATA;
                    end else begin
                        cnt <= cnt - ONE;
                    end
                end
                PH_DATA: begin
                    if (bit_end) begin
                        cnt <= div_q - ONE;
                        if (idx == last_idx(cfg_q.len)) begin
                            stop_left <= cfg_q.two_stop;
                            if (cfg_q.par_en) begin
                                txd <= parity_bit(shreg, cfg_q);
                                ph  <= PH_PAR;
                            end else begin
                                txd <= 1'b1;
                                ph  <= PH_STOP;
                            end
                        end else begin
                            idx <= idx + IDX_W'(1);
                            txd <= shreg[idx + IDX_W'(1)];
                        end
                    end else begin
                        cnt <= cnt - ONE;
                    end
                end
                PH_PAR: begin
                    if (bit_end) begin
                        cnt <= div_q - ONE;
                        txd <= 1'b1;
                        ph  <= PH_STOP;
                    end else begin
                        cnt <= cnt - ONE;
                    end
                end
                PH_STOP: begin
                    if (bit_end) begin
                        if (stop_left) begin
                            stop_left <= 1'b0;
                            cnt       <= div_q - ONE;
                        end else begin
                            ph <= PH_IDLE;
                        end
                    end else begin
                        cnt <= cnt - ONE;
                    end
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    p_pop_single_r6: assert property (@(posedge clk) disable iff (rst)
        fifo_pop |=> !fifo_pop);
    p_start_after_pop_r2: assert property (@(posedge clk) disable iff (rst)
        fifo_pop |=> !txd);
    p_idle_line_high_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> txd);
    p_stop_high_r4: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_STOP) |-> txd);
endmodule

// File: rtl/uart_fe_rx.sv
module uart_fe_rx
    import uart_fe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [DIV_W-1:0]  div,
    input  frame_cfg_t        cfg_in,
    input  logic              rxd,
    input  logic              fifo_full,
    output logic              push,
    output logic [DATA_W-1:0] push_data,
    output logic [STAT_W-1:0] push_status
);
    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    phase_t            ph;
    frame_cfg_t        cfg_q;
    logic [DIV_W-1:0]  cnt;
    logic [DIV_W-1:0]  div_q;
    logic [DATA_W-1:0] data;
    logic [IDX_W-1:0]  idx;
    logic              par_s;
    logic              stop_left;
    logic              frm_err;
    logic              ovr_pend;
    logic              bit_end;
    logic              final_smp;
    logic              fe, pe, brk;

    assign bit_end   = (cnt == '0);
    assign final_smp = (ph == PH_STOP) && bit_end && !stop_left;

    always_comb begin
        fe  = frm_err || !rxd;
        pe  = cfg_q.par_en && (par_s != parity_bit(data, cfg_q));
        brk = (data == '0) && (!cfg_q.par_en || !par_s) && !rxd
              && (!cfg_q.two_stop || frm_err);
        push        = final_smp && !fifo_full;
        push_data   = data;
        push_status = '0;
        push_status[ST_BRK] = brk;
        push_status[ST_OVR] = ovr_pend;
        push_status[ST_FRM] = fe && !brk;
        push_status[ST_PAR] = pe && !brk;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph        <= PH_IDLE;
            cfg_q     <= '0;
            cnt       <= '0;
            div_q     <= DIV_W'(2);
            data      <= '0;
            idx       <= '0;
            par_s     <= 1'b0;
            stop_left <= 1'b0;
            frm_err   <= 1'b0;
            ovr_pend  <= 1'b0;
        end else begin
            case (ph)
                PH_IDLE: begin
                    if (!rxd) begin
                        div_q   <= eff_div(div);
                        cnt     <= (eff_div(div) >> 1) - ONE;
                        cfg_q   <= cfg_in;
                        frm_err <= 1'b0;
                        ph      <= PH_START;
                    end
                end
                PH_START: begin
                    if (bit_end) begin
                        if (!rxd) begin
                            cnt  <= div_q - ONE;
                            idx  <= '0;
                            data <= '0;
                            ph   <= PH_DATA;
                        end else begin
                            ph <= PH_IDLE;
                        end
                    end else begin
                        cnt <= cnt - ONE;
                    end
                end
                PH_DATA: begin
                    if (bit_end) begin
                        data[idx] <= rxd;
                        cnt       <= div_q - ONE;
                        if (idx == last_idx(cfg_q.len)) begin
                            stop_left <= cfg_q.two_stop;
                            ph        <= cfg_q.par_en ? PH_PAR : PH_STOP;
                        end else begin
                            idx <= idx + IDX_W'(1);
                        end
                    end else begin
                        cnt <= cnt - ONE;
                    end
                end
                PH_PAR: begin
                    if (bit_end) begin
                        par_s <= rxd;
                        cnt   <= div_q - ONE;
                        ph    <= PH_STOP;
                    end else begin
                        cnt <= cnt - ONE;
                    end
                end
                PH_STOP: begin
                    if (bit_end) begin
                        if (stop_left) begin
                            stop_left <= 1'b0;
                            cnt       <= div_q - ONE;
                            if (!rxd) frm_err <= 1'b1;
                        end else begin
                            ovr_pend <= fifo_full;
                            ph       <= rxd ? PH_IDLE : PH_HOLD;
                        end
                    end else begin
                        cnt <= cnt - ONE;
                    end
                end
                PH_HOLD: begin
                    if (rxd) ph <= PH_IDLE;
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    p_push_single_r9: assert property (@(posedge clk) disable iff (rst)
        push |=> !push);
    p_break_masks_r11: assert property (@(posedge clk) disable iff (rst)
        (push && push_status[ST_BRK]) |->
            (!push_status[ST_FRM] && !push_status[ST_PAR] && push_data == '0));
    p_glitch_rejected_r8: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_START && bit_end && rxd) |=> (ph == PH_IDLE));
    p_hold_low_r11: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_HOLD && !rxd) |=> (ph == PH_HOLD));
endmodule

// File: rtl/uart_frame_engine.sv
module uart_frame_engine
    import uart_fe_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [DIV_LO_W-1:0] baud_div_lo,
    input  logic [DIV_HI_W-1:0] baud_div_hi,
    input  logic [LCR_W-1:0]    line_ctrl,
    input  logic                loop_en,
    input  logic                tx_fifo_empty,
    input  logic [DATA_W-1:0]   tx_fifo_data,
    output logic                tx_fifo_pop,
    input  logic                rx_fifo_full,
    output logic                rx_fifo_push,
    output logic [DATA_W-1:0]   rx_fifo_data,
    output logic [STAT_W-1:0]   rx_fifo_status,
    output logic                tx_done,
    input  logic                serial_in,
    output logic                serial_out
);
    logic [DIV_W-1:0] div;
    frame_cfg_t       cfg;
    logic             tx_busy;
    logic             rx_raw;
    logic             rx_line;

    assign div     = {baud_div_hi, baud_div_lo};
    assign cfg     = decode_lcr(line_ctrl);
    assign rx_raw  = loop_en ? serial_out : serial_in;
    assign tx_done = !tx_busy && tx_fifo_empty;

    uart_fe_tx u_tx (
        .clk        (clk),
        .rst        (rst),
        .div        (div),
        .cfg_in     (cfg),
        .fifo_empty (tx_fifo_empty),
        .fifo_data  (tx_fifo_data),
        .fifo_pop   (tx_fifo_pop),
        .txd        (serial_out),
        .busy       (tx_busy)
    );

    uart_fe_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (rx_raw),
        .q   (rx_line)
    );

    uart_fe_rx u_rx (
        .clk         (clk),
        .rst         (rst),
        .div         (div),
        .cfg_in      (cfg),
        .rxd         (rx_line),
        .fifo_full   (rx_fifo_full),
        .push        (rx_fifo_push),
        .push_data   (rx_fifo_data),
        .push_status (rx_fifo_status)
    );

    p_done_idle_r7: assert property (@(posedge clk) disable iff (rst)
        tx_done |-> serial_out);
endmodule

// File: tb/test_uart_frame_engine.sv
module test_uart_frame_engine;
    localparam int CLK_PERIOD   = 10;
    localparam int WATCHDOG_CYC = 190000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] baud_div_lo = 16'd8;
    logic [4:0]  baud_div_hi = 5'd0;
    logic [5:0]  line_ctrl = 6'h1C;
    logic        loop_en = 1'b0;
    logic        tx_fifo_empty;
    logic [7:0]  tx_fifo_data;
    logic        tx_fifo_pop;
    logic        rx_fifo_full = 1'b0;
    logic        rx_fifo_push;
    logic [7:0]  rx_fifo_data;
    logic [7:0]  rx_fifo_status;
    logic        tx_done;
    logic        serial_in = 1'b1;
    logic        serial_out;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_frame_engine i_uart_frame_engine (
        .clk(clk), .rst(rst),
        .baud_div_lo(baud_div_lo), .baud_div_hi(baud_div_hi),
        .line_ctrl(line_ctrl), .loop_en(loop_en),
        .tx_fifo_empty(tx_fifo_empty), .tx_fifo_data(tx_fifo_data), .tx_fifo_pop(tx_fifo_pop),
        .rx_fifo_full(rx_fifo_full), .rx_fifo_push(rx_fifo_push),
        .rx_fifo_data(rx_fifo_data), .rx_fifo_status(rx_fifo_status),
        .tx_done(tx_done), .serial_in(serial_in), .serial_out(serial_out)
    );

    // show-ahead transmit FIFO model
    logic [7:0] txq [0:255];
    logic [7:0] tx_wr = 8'd0;
    logic [7:0] tx_rd = 8'd0;
    assign tx_fifo_empty = (tx_wr == tx_rd);
    assign tx_fifo_data  = txq[tx_rd];
    always @(posedge clk) if (tx_fifo_pop) tx_rd <= tx_rd + 8'd1;

    // receive capture
    logic [7:0] rxd_q [0:255];
    logic [7:0] rxs_q [0:255];
    int rx_cnt = 0;
    always @(posedge clk) begin
        if (rx_fifo_push) begin
            rxd_q[rx_cnt[7:0]] <= rx_fifo_data;
            rxs_q[rx_cnt[7:0]] <= rx_fifo_status;
            rx_cnt <= rx_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int nb(input logic [5:0] l);
        return 5 + int'(l[3:2]);
    endfunction
    function automatic logic [7:0] msk(input logic [5:0] l);
        return 8'hFF >> (3 - int'(l[3:2]));
    endfunction
    function automatic logic expar(input logic [7:0] d, input logic [5:0] l);
        return (^(d & msk(l))) ^ l[0];
    endfunction
    function automatic int flen(input logic [5:0] l);
        return 1 + nb(l) + int'(l[1]) + ((l[5:4] == 2'b11) ? 2 : 1);
    endfunction
    function automatic logic fbit(input logic [7:0] d, input logic [5:0] l, input int k);
        if (k == 0) return 1'b0;
        if (k <= nb(l)) return d[k-1];
        if (l[1] && k == nb(l) + 1) return expar(d, l);
        return 1'b1;
    endfunction
    function automatic logic [11:0] make_frame(input logic [7:0] d, input logic [5:0] l);
        logic [11:0] v;
        v = '1;
        for (int k = 0; k < 12; k++) if (k < flen(l)) v[k] = fbit(d, l, k);
        return v;
    endfunction

    int cur_div = 8;
    task automatic set_cfg(input logic [5:0] lcr, input int div);
        line_ctrl   = lcr;
        baud_div_lo = div[15:0];
        baud_div_hi = div[20:16];
        cur_div     = div;
    endtask

    task automatic push_tx(input logic [7:0] d);
        txq[tx_wr] = d;
        tx_wr = tx_wr + 8'd1;
    endtask

    task automatic drive_frame(input logic [11:0] v, input int n);
        for (int i = 0; i < n; i++) begin
            serial_in = v[i];
            repeat (cur_div) @(negedge clk);
        end
        serial_in = 1'b1;
        repeat (cur_div + 6) @(negedge clk);
    endtask

    task automatic wait_rx(input int target);
        int lim = 0;
        while (rx_cnt < target && lim < 20000) begin
            @(negedge clk);
            lim++;
        end
    endtask

    task automatic wait_tx_low();
        int lim = 0;
        @(negedge clk);
        while (serial_out !== 1'b0 && lim < 1000) begin
            @(negedge clk);
            lim++;
        end
    endtask

    // transmit waveform and frame-length check
    task automatic tx_wave(input logic [7:0] d, input logic [5:0] l, input int div);
        int cyc = 0;
        int fl;
        string tag;
        loop_en = 1'b0;
        set_cfg(l, div);
        fl = flen(l);
        push_tx(d);
        wait_tx_low();
        while (tx_done !== 1'b1 && cyc < 20000) begin
            if (cyc % div == div / 2) begin
                int k = cyc / div;
                if (k <= nb(l)) tag = "R2 bit";
                else if (l[1] && k == nb(l) + 1) tag = "R3 parity bit";
                else tag = "R4 stop bit";
                if (k < fl) chk(serial_out === fbit(d, l, k), tag, {31'd0, serial_out}, {31'd0, fbit(d, l, k)});
            end
            @(negedge clk);
            cyc++;
        end
        chk(cyc == fl * div, "R7 tx_done rise time", cyc, fl * div);
    endtask

    task automatic rx_expect(input int idx, input logic [7:0] d, input logic [7:0] s, input string req);
        chk(rx_cnt > idx, {req, " char received"}, rx_cnt, idx + 1);
        chk(rxd_q[idx[7:0]] == d, {req, " data"}, rxd_q[idx[7:0]], d);
        chk(rxs_q[idx[7:0]] == s, {req, " status"}, rxs_q[idx[7:0]], s);
    endtask

    initial begin
        int base;
        int cnt;
        logic [11:0] v;
        logic [7:0] e0, e1;
        logic [5:0] l;
        int dv;
        void'($urandom(32'h5EED));

        repeat (4) @(negedge clk);
        chk(serial_out === 1'b1, "R1 line high in reset", {31'd0, serial_out}, 1);
        chk(rx_fifo_push === 1'b0 && tx_fifo_pop === 1'b0, "R1 no push/pop in reset",
            {30'd0, rx_fifo_push, tx_fifo_pop}, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(serial_out === 1'b1 && tx_done === 1'b1, "R1 idle after reset",
            {30'd0, serial_out, tx_done}, 3);
        chk(rx_cnt == 0, "R1 no receive after reset", rx_cnt, 0);

        // directed transmit waveforms: 5N1, 6E2, 7O1, 8E1, 8N2
        tx_wave(8'h15, 6'h10, 6);
        tx_wave(8'h2B, 6'h36, 5);
        tx_wave(8'h4D, 6'h1B, 7);
        tx_wave(8'hC3, 6'h1E, 4);
        tx_wave(8'h96, 6'h3C, 9);
        chk(tx_rd == tx_wr, "R6 one pop per frame", tx_rd, tx_wr);

        // loopback, random configuration; serial_in held low must not matter
        loop_en = 1'b1;
        repeat (4) @(negedge clk);
        serial_in = 1'b0;
        for (int t = 0; t < 12; t++) begin
            l  = {($urandom % 2) ? 2'b11 : 2'b01, 2'($urandom % 4), 1'($urandom % 2), 1'($urandom % 2)};
            dv = 4 + int'($urandom % 21);
            set_cfg(l, dv);
            e0 = 8'($urandom);
            e1 = 8'($urandom);
            base = rx_cnt;
            push_tx(e0);
            push_tx(e1);
            wait_rx(base + 2);
            rx_expect(base, e0 & msk(l), 8'h00, "R13 loopback R2 R3 R4 first");
            rx_expect(base + 1, e1 & msk(l), 8'h00, "R13 loopback R6 second");
            repeat (2 * dv) @(negedge clk);
        end
        chk(tx_done === 1'b1 && tx_rd == tx_wr, "R7 done after loopback", {31'd0, tx_done}, 1);
        serial_in = 1'b1;
        repeat (4) @(negedge clk);
        loop_en = 1'b0;
        repeat (4) @(negedge clk);

        // parity error on 8E1
        set_cfg(6'h1E, 16);
        base = rx_cnt;
        v = make_frame(8'h5A, 6'h1E);
        v[9] = ~v[9];
        drive_frame(v, flen(6'h1E));
        rx_expect(base, 8'h5A, 8'h04, "R10 parity error");

        // framing error on 7N1
        set_cfg(6'h18, 16);
        base = rx_cnt;
        v = make_frame(8'h33, 6'h18);
        v[flen(6'h18) - 1] = 1'b0;
        drive_frame(v, flen(6'h18));
        rx_expect(base, 8'h33, 8'h08, "R10 framing error");

        // framing error on the second stop bit of 6N2
        set_cfg(6'h34, 12);
        base = rx_cnt;
        v = make_frame(8'h2C, 6'h34);
        v[flen(6'h34) - 1] = 1'b0;
        drive_frame(v, flen(6'h34));
        rx_expect(base, 8'h2C, 8'h08, "R4 second stop checked");

        // break with odd parity enabled: flags masked
        set_cfg(6'h1F, 16);
        base = rx_cnt;
        drive_frame(12'h000, flen(6'h1F) + 2);
        rx_expect(base, 8'h00, 8'h80, "R11 break");
        chk(rx_cnt == base + 1, "R11 single char for break", rx_cnt, base + 1);
        drive_frame(make_frame(8'hA5, 6'h1F), flen(6'h1F));
        rx_expect(base + 1, 8'hA5, 8'h00, "R11 recovery after break");

        // glitch shorter than half a bit
        set_cfg(6'h1C, 16);
        base = rx_cnt;
        serial_in = 1'b0;
        repeat (4) @(negedge clk);
        serial_in = 1'b1;
        repeat (48) @(negedge clk);
        chk(rx_cnt == base, "R8 glitch ignored", rx_cnt, base);
        drive_frame(make_frame(8'h6E, 6'h1C), flen(6'h1C));
        rx_expect(base, 8'h6E, 8'h00, "R8 normal frame after glitch");

        // overrun
        set_cfg(6'h1C, 10);
        base = rx_cnt;
        rx_fifo_full = 1'b1;
        drive_frame(make_frame(8'h11, 6'h1C), flen(6'h1C));
        chk(rx_cnt == base, "R12 dropped when full", rx_cnt, base);
        rx_fifo_full = 1'b0;
        drive_frame(make_frame(8'h22, 6'h1C), flen(6'h1C));
        rx_expect(base, 8'h22, 8'h10, "R12 overrun flagged");
        drive_frame(make_frame(8'h44, 6'h1C), flen(6'h1C));
        rx_expect(base + 1, 8'h44, 8'h00, "R12 overrun cleared");

        // divider clamp: value 1 acts as 2
        set_cfg(6'h1C, 1);
        push_tx(8'h01);
        wait_tx_low();
        cnt = 0;
        while (serial_out === 1'b0 && cnt < 100) begin
            @(negedge clk);
            cnt++;
        end
        chk(cnt == 2, "R5 divider clamp", cnt, 2);
        while (tx_done !== 1'b1) @(negedge clk);

        // divider upper bits: 0x10000 cycles per bit
        set_cfg(6'h1C, 32'h10000);
        push_tx(8'h01);
        wait_tx_low();
        cnt = 0;
        while (serial_out === 1'b0 && cnt < 70000) begin
            @(negedge clk);
            cnt++;
        end
        chk(cnt == 65536, "R5 21-bit divider", cnt, 65536);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(serial_out === 1'b1 && tx_fifo_pop === 1'b0, "R1 reset aborts frame",
            {30'd0, serial_out, tx_fifo_pop}, 2);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(tx_done === 1'b1, "R7 done with empty fifo after reset", {31'd0, tx_done}, 1);

        if (!finished) begin
            finished = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG_CYC) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule